// File: doc/BRIEF.md
# Reset Cause Register

This block keeps a 32-bit word that says why the system last came out of reset. It also lets software ask for a new reset of one of two kinds: a soft power-on reset or a soft externally-initiated reset. The register sits on a 32-bit register bus. It lives in a domain that stays up across system resets. Only its own hard power-on reset (`rst_n`) clears it. A one-cycle pulse on `rst_evt` tells it that a system reset has just been applied. Software requests leave the block as a one-cycle pulse on `rst_req`. The reset tree and push-button debouncing sit outside this block.

The key state is a two-state phase machine. It records whether the next system reset counts as a power-on reset.
- State `PH_COLD` means the next reset counts as power-on. It is entered on hard reset.
- State `PH_WARM` means the next reset does not count as power-on.
- Transition `T_FIRST_RESET` moves `PH_COLD` to `PH_WARM` on a reset event. On that event the register is loaded with only the power-on cause set.
- Transition `T_SOFT_POR` moves `PH_WARM` to `PH_COLD` when software writes the soft power-on bit.
- Every other case holds the state. This includes a reset event in `PH_WARM` and a soft power-on write in `PH_COLD`.

The implemented bits split into two kinds. Cause bits are cleared by writing one. Request bits are set by writing one and are never cleared by writing zero.

Top module: `rstcause_reg`

## Requirements
- R1: After `rst_n` is released, the data word reads 0x00000000 and `rst_req` is low. The first `rst_evt` then counts as a power-on reset.
- R2: The implemented bits have these meanings:
  - bit 31: power-on cause
  - bit 30: soft power-on request
  - bit 29: soft externally-initiated reset request
  - bit 28: button power-on cause
  - bit 27: button externally-initiated cause

  Bits 26:0 always read zero, and their write data is discarded.
- R3: The data word sits at `BASE_ADDR+4`: address bits [ADDR_W-1:3] equal those of `BASE_ADDR` and address bit 2 is 1. The word at `BASE_ADDR+0` and every other address read zero, and writes to them change nothing.
- R4: Writing one to bit 31, 28 or 27 clears that bit. Writing zero leaves it unchanged.
- R5: Writing one to bit 30 or 29 sets that bit. Writing zero never clears it.
- R6: A write to the data word with bit 30 or bit 29 set drives `rst_req` high for exactly the one cycle that follows the write edge. Any other write leaves it low.
- R7: A write with bit 30 set makes the next `rst_evt` a power-on reset. A write with only bit 29 set does not. When both bits are written, bit 30 wins.
- R8: An `rst_evt` while a power-on reset is pending loads the register with 0x80000000 and clears the pending flag.
- R9: An `rst_evt` while no power-on reset is pending leaves the register unchanged.
- R10: A write in the same cycle as `rst_evt` is discarded and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard power-on reset, active low, asynchronous |
| bus_addr | input | ADDR_W | Register bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_evt | input | 1 | One-cycle pulse: a system reset has been applied |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `ADDR_W` = 16 and `BASE_ADDR` = 0xF020. With these values it can reach the data word, the zero word beside it, and a nearby unrelated address that shares the upper address bits.

A behavioural model runs alongside the design. It tracks the register value, the pending flag and the expected request, and is compared against the design every cycle. Both phase transitions are exercised, as is each hold case. The sequences cover a soft externally-initiated request that must not make the next reset a power-on one. They also cover both request bits written together, a write that collides with a reset event, and back-to-back requests.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    // Register word width and the implemented field window
    localparam int CAUSE_W  = 32;
    localparam int FIELD_LO = 27;
    localparam int FIELD_N  = CAUSE_W - FIELD_LO;

    // Bit positions (software decodes these)
    localparam int B_PWRON  = 31;
    localparam int B_SWPOR  = 30;
    localparam int B_SWXIR  = 29;
    localparam int B_BTNPOR = 28;
    localparam int B_BTNXIR = 27;

    // Bits with write-one-to-set behaviour; the rest of the window is write-one-to-clear
    localparam logic [CAUSE_W-1:0] SET_MASK   = (CAUSE_W'(1) << B_SWPOR) | (CAUSE_W'(1) << B_SWXIR);

    // Value loaded on a reset event that counts as power-on
    localparam logic [CAUSE_W-1:0] COLD_VALUE = CAUSE_W'(1) << B_PWRON;

    typedef enum logic [0:0] {
        PH_COLD = 1'b0,
        PH_WARM = 1'b1
    } phase_t;

endpackage

// File: rtl/rcc_decode.sv
module rcc_decode #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'hF020
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              data_sel
);
    localparam int WORD_BIT = 2;
    localparam int BLK_LSB  = 3;

    logic unused_bytesel;
    assign unused_bytesel = ^addr[WORD_BIT-1:0];

    always_comb begin
        data_sel = (addr[ADDR_W-1:BLK_LSB] == BASE_ADDR[ADDR_W-1:BLK_LSB]) && addr[WORD_BIT];
    end
endmodule

// File: rtl/rcc_phase_fsm.sv
module rcc_phase_fsm
    import rcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic soft_por_wr,
    output logic cold
);
    phase_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_COLD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_COLD: if (evt)                 state_nx = PH_WARM;  // T_FIRST_RESET
            PH_WARM: if (!evt && soft_por_wr) state_nx = PH_COLD;  // T_SOFT_POR
            default:                          state_nx = PH_COLD;
        endcase
    end

    always_comb begin
        cold = (state == PH_COLD);
    end

    // R8
    first_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> state == PH_WARM);

    // R7
    soft_por_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && soft_por_wr) |=> state == PH_COLD);
endmodule

// File: rtl/rcc_cause_bank.sv
module rcc_cause_bank
    import rcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt,
    input  logic               cold,
    input  logic               wr,
    input  logic [FIELD_N-1:0] wfield,
    output logic [CAUSE_W-1:0] cause
);
    logic [FIELD_N-1:0] fld;

    for (genvar i = 0; i < FIELD_N; i++) begin : g_bit
        localparam int  BPOS   = FIELD_LO + i;
        localparam bit  IS_SET = SET_MASK[BPOS];
        localparam bit  LOADV  = COLD_VALUE[BPOS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fld[i] <= 1'b0;
            end else if (evt) begin
                if (cold) fld[i] <= LOADV;
            end else if (wr && wfield[i]) begin
                fld[i] <= IS_SET;
            end
        end
    end

    assign cause = {fld, {FIELD_LO{1'b0}}};

    // R8
    cold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && cold) |=> cause == COLD_VALUE);

    // R9
    warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !cold) |=> cause == $past(cause));

    // R5
    sticky_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && cause[B_SWPOR]) |=> cause[B_SWPOR]);

    // R5
    sticky_xir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && cause[B_SWXIR]) |=> cause[B_SWXIR]);
endmodule

// File: rtl/rcc_req_pulse.sv
module rcc_req_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req <= 1'b0;
        else        req <= go;
    end
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
    import rcc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'hF020
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [CAUSE_W-1:0] bus_wdata,
    output logic [CAUSE_W-1:0] bus_rdata,
    input  logic               rst_evt,
    output logic               rst_req
);
    logic               data_sel;
    logic               wr_eff;
    logic               soft_por_wr;
    logic               req_go;
    logic               cold;
    logic [CAUSE_W-1:0] cause;
    logic               unused_wlow;

    assign unused_wlow = ^bus_wdata[FIELD_LO-1:0];

    rcc_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr     (bus_addr),
        .data_sel (data_sel)
    );

    // A reset event discards a write in the same cycle
    assign wr_eff      = bus_wr && data_sel && !rst_evt;
    assign soft_por_wr = wr_eff && bus_wdata[B_SWPOR];
    assign req_go      = wr_eff && (bus_wdata[B_SWPOR] || bus_wdata[B_SWXIR]);

    rcc_phase_fsm u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (rst_evt),
        .soft_por_wr (soft_por_wr),
        .cold        (cold)
    );

    rcc_cause_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (rst_evt),
        .cold   (cold),
        .wr     (wr_eff),
        .wfield (bus_wdata[CAUSE_W-1:FIELD_LO]),
        .cause  (cause)
    );

    rcc_req_pulse u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (req_go),
        .req   (rst_req)
    );

    assign bus_rdata = data_sel ? cause : '0;

    // R6
    req_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cause[B_SWPOR] || cause[B_SWXIR]));

    // R10
    evt_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> !rst_req);
endmodule

// File: tb/test_rstcause_reg.sv
`timescale 1ns/1ps
module test_rstcause_reg;
    localparam int             AW   = 16;
    localparam logic [AW-1:0]  BASE = 16'hF020;
    localparam logic [AW-1:0]  DATA = BASE + 16'd4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] bus_addr;
    logic          bus_wr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          rst_evt;
    logic          rst_req;

    always #2.5 clk = ~clk;

    rstcause_reg #(.ADDR_W(AW), .BASE_ADDR(BASE)) i_rstcause_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_evt(rst_evt),
        .rst_req(rst_req)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural model
    logic [31:0] m_reg;
    bit          m_cold;
    bit          m_req;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit is_data(logic [AW-1:0] a);
        return (a[AW-1:3] == BASE[AW-1:3]) && a[2];
    endfunction

    task automatic cyc(string tag, bit we, logic [AW-1:0] a, logic [31:0] d, bit evt);
        logic [31:0] msk;
        bus_wr = we; bus_addr = a; bus_wdata = d; rst_evt = evt;
        #1;
        chk({tag, " rdata"}, bus_rdata, is_data(a) ? m_reg : 32'h0);
        chk({tag, " req"}, {31'h0, rst_req}, {31'h0, m_req});
        @(posedge clk);
        msk   = d & 32'hF800_0000;
        m_req = 1'b0;
        if (evt) begin
            if (m_cold) begin
                m_reg  = 32'h8000_0000;
                m_cold = 1'b0;
            end
        end else if (we && is_data(a)) begin
            m_reg = (m_reg & ~(msk & 32'h9800_0000)) | (msk & 32'h6000_0000);
            m_req = msk[30] | msk[29];
            if (msk[30]) m_cold = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        cyc(tag, 1'b0, DATA, 32'h0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; rst_evt = 1'b0;
        m_reg = 32'h0; m_cold = 1'b1; m_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        idle("R1 reset state hold");
        // R8: first reset event loads the power-on cause
        cyc("R8 first event", 1'b0, DATA, 32'h0, 1'b1);
        idle("R8 cold load");
        // R3: neighbour word and other address
        cyc("R3 zero word read", 1'b1, BASE, 32'hFFFF_FFFF, 1'b0);
        cyc("R3 other address", 1'b1, BASE + 16'h10, 32'hFFFF_FFFF, 1'b0);
        idle("R3 writes ignored");
        // R4 / R2: zero write and low bits ignored, then clear bit 31
        cyc("R4 zero write", 1'b1, DATA, 32'h07FF_FFFF, 1'b0);
        idle("R2 low bits ignored");
        cyc("R4 clear bit31", 1'b1, DATA, 32'h8000_0000, 1'b0);
        idle("R4 cleared");
        // R5 / R6: soft XIR request
        cyc("R5 set bit29", 1'b1, DATA, 32'h2000_0000, 1'b0);
        idle("R6 pulse after XIR");
        idle("R6 pulse one cycle");
        cyc("R5 zero write no clear", 1'b1, DATA, 32'h0, 1'b0);
        idle("R5 sticky");
        // R7 / R9: XIR alone does not make next reset power-on
        cyc("R9 warm event", 1'b0, DATA, 32'h0, 1'b1);
        idle("R9 register unchanged");
        // R7 / R8: soft POR arms a power-on reset
        cyc("R7 soft POR write", 1'b1, DATA, 32'h4000_0000, 1'b0);
        idle("R6 pulse after POR");
        cyc("R8 armed event", 1'b0, DATA, 32'h0, 1'b1);
        idle("R8 reload");
        // R7 precedence: both bits
        cyc("R7 both bits", 1'b1, DATA, 32'h6000_0000, 1'b0);
        idle("R7 both pulse");
        cyc("R7 both event", 1'b0, DATA, 32'h0, 1'b1);
        idle("R7 power-on after both");
        // R10: write colliding with event
        cyc("R10 collide", 1'b1, DATA, 32'hE000_0000, 1'b1);
        idle("R10 no request");
        idle("R10 value kept");
        // R4 / R5 mixed write
        cyc("R4 all ones", 1'b1, DATA, 32'hFFFF_FFFF, 1'b0);
        idle("R4 mixed result");
        // R6 back-to-back requests
        cyc("R6 b2b first", 1'b1, DATA, 32'h2000_0000, 1'b0);
        cyc("R6 b2b second", 1'b1, DATA, 32'h4000_0000, 1'b0);
        idle("R6 b2b pulse");
        idle("R6 b2b end");
        // R6: non-request write gives no pulse
        cyc("R6 plain write", 1'b1, DATA, 32'h1800_0000, 1'b0);
        idle("R6 no pulse");
        idle("R1 final");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule